// File: doc/BRIEF.md
# Serial Peripheral Port with Sequenced Status Flags

This block is an 8-bit SPI port that sits on a simple register bus with three locations: a control word, a control/status word and a data word. It can act as bus master, generating a mode 0 clock (idle low, data sampled on the rising edge and changed on the falling edge), or as a slave that follows an external clock while its select input is low. Bytes go out MSB first.

Software learns what happened through four hardware-set flags: transfer complete, write collision, overrun and mode fault. None of them is cleared by writing to it. Instead, each one clears after a fixed order of bus accesses. A status read arms a tracker, and the next data access (or, for mode fault, the next control write) consumes the arm. While a finished byte has not yet been acknowledged, data writes are refused, so software cannot start a new byte by mistake before it has seen the status.

Slave select comes either from the external pin or, under software management, from a status bit. A disable bit releases the serial data output. Pin inputs used in slave mode pass through a synchronizer.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset the control word (address 0) reads 0x00, the status word (address 1) reads 0x00, the data word (address 2) reads 0x00, `irq_o` is 0 and all output enables are 0.
- R2: With control bit 0 (enable) and bit 1 (master) set, an accepted data write sends the byte MSB first on `mosi_o` with mode 0 timing while sampling `miso_i`. At the end of the byte, the received byte becomes readable at address 2 and status bit 7 (complete) becomes 1. `sck_o` is low whenever no byte is in flight.
- R3: `irq_o` is 1 exactly when control bit 2 (interrupt enable) is 1 and at least one of status bits 7, 5 or 4 is 1.
- R4: Status bit 7 clears only on a data read or accepted data write whose most recent preceding access of status or data was a status read. A data access with no such status read leaves it set, and repeated status reads keep the tracker armed.
- R5: While status bit 7 is 1 and no status read has occurred since the last data access, a data write is ignored: no byte starts and no flag changes.
- R6: An accepted data write while a byte is in flight sets status bit 6 (collision) and does not disturb the byte in flight. Bit 6 clears with the same status-then-data sequence as bit 7.
- R7: When a byte finishes while status bit 7 is still 1, status bit 5 (overrun) is set and the data word keeps the earlier byte. Any status read clears bit 5.
- R8: In master mode, an internal slave-select level of 0 sets status bit 4 (mode fault), clears control bits 0 and 1, and drops all output enables. Bit 4 clears on a control write that follows a status read taken while bit 4 was 1. A control write without such a read leaves it set.
- R9: Status bit 2 (output disable) at 1 holds `mosi_oe_o` and `miso_oe_o` at 0. At 0, the data output of the active mode is enabled.
- R10: Status bit 1 at 1 takes the internal slave-select level from status bit 0 (0 selected, 1 deselected) and ignores `ss_ni`. At 0, the level comes from `ss_ni`.
- R11: Status bits 7 to 4 are read-only, bit 3 always reads 0, and bits 2 to 0 read back as written.
- R12: In slave mode (control bit 0 set, bit 1 clear), while selected, the block shifts a byte in from `mosi_i` on rising `sck_i` and drives the preloaded byte MSB first on `miso_o`. `miso_oe_o` is 1 only while the block is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; read side effects occur at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe_o | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe_o | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data in |
| ss_ni | input | 1 | External slave select, active low |

## Verification
On every cycle, the bound checker watches the causal links between flag logic and shift engine. It checks that completion always raises the complete flag and that the complete flag only falls from an armed tracker. It also checks that a refused write never starts the engine, that collision arises only while busy, that the data word holds still on overrun, and that a mode fault always coincides with enable going low. Only the bench scenarios can show the observable orderings: which status/data/control sequences clear which flag, that a skipped status read leaves flags set, the exact bit order on the serial lines in both modes, and the interplay of software and pin slave select.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_MSTR = 1;
  localparam int unsigned CTRL_IE   = 2;

  localparam int unsigned ST_SSI = 0;
  localparam int unsigned ST_SSM = 1;
  localparam int unsigned ST_SOD = 2;

  // packed order matches status bits 7..4
  typedef struct packed {
    logic done;
    logic coll;
    logic ovrn;
    logic fault;
  } flags_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DW       = 8,
  parameter int unsigned SCK_HALF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mstr_i,
  input  logic          load_i,
  input  logic [DW-1:0] tx_i,
  input  logic          miso_i,
  input  logic          s_sck_i,
  input  logic          s_mosi_i,
  input  logic          s_sel_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          sck_o,
  output logic          sdo_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);
  localparam int unsigned HW    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [DW-1:0]    sreg;
  logic             smp;
  logic [CNT_W-1:0] bitcnt;
  logic             run;
  logic             sck_q;
  logic             sck_d;
  logic [HW-1:0]    tick;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg   <= '0;
      smp    <= 1'b0;
      bitcnt <= '0;
      run    <= 1'b0;
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
      tick   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sck_d  <= s_sck_i;
      if (!en_i) begin
        run    <= 1'b0;
        sck_q  <= 1'b0;
        bitcnt <= '0;
        tick   <= '0;
      end else if (mstr_i) begin
        if (!run) begin
          if (load_i) begin
            sreg   <= tx_i;
            run    <= 1'b1;
            tick   <= '0;
            bitcnt <= '0;
            sck_q  <= 1'b0;
          end
        end else if (tick == HW'(SCK_HALF - 1)) begin
          tick <= '0;
          if (!sck_q) begin
            sck_q  <= 1'b1;
            smp    <= miso_i;
            bitcnt <= bitcnt + CNT_W'(1);
          end else begin
            sck_q <= 1'b0;
            sreg  <= {sreg[DW-2:0], smp};
            if (bitcnt == CNT_W'(DW)) begin
              run    <= 1'b0;
              done_q <= 1'b1;
              bitcnt <= '0;
            end
          end
        end else begin
          tick <= tick + HW'(1);
        end
      end else begin
        if (!s_sel_i) begin
          bitcnt <= '0;
          if (load_i) sreg <= tx_i;
        end else if (s_sck_i && !sck_d) begin
          smp    <= s_mosi_i;
          bitcnt <= bitcnt + CNT_W'(1);
        end else if (!s_sck_i && sck_d && bitcnt != '0) begin
          sreg <= {sreg[DW-2:0], smp};
          if (bitcnt == CNT_W'(DW)) begin
            done_q <= 1'b1;
            bitcnt <= '0;
          end
        end else if (load_i) begin
          sreg <= tx_i;
        end
      end
    end
  end

  assign busy_o = run | (!mstr_i && bitcnt != '0);
  assign done_o = done_q;
  assign rx_o   = sreg;
  assign sck_o  = sck_q;
  assign sdo_o  = sreg[DW-1];
endmodule

// File: rtl/spi_flag_seq.sv
module spi_flag_seq
  import spi_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   stat_rd_i,
  input  logic   data_rd_i,
  input  logic   data_wr_i,
  input  logic   ctrl_wr_i,
  input  logic   done_i,
  input  logic   busy_i,
  input  logic   fault_evt_i,
  output flags_t flags_o,
  output logic   armed_o,
  output logic   wr_accept_o,
  output logic   rx_load_o
);
  flags_t fl_q;
  logic   armed_q;
  logic   fault_arm_q;
  logic   seq_clr;

  assign wr_accept_o = data_wr_i && !(fl_q.done && !armed_q);
  assign seq_clr     = armed_q && (data_rd_i || wr_accept_o);
  assign rx_load_o   = done_i && !fl_q.done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q        <= '0;
      armed_q     <= 1'b0;
      fault_arm_q <= 1'b0;
    end else begin
      // status read (re)arms; any data access consumes the arm
      if (stat_rd_i)                     armed_q <= 1'b1;
      else if (data_rd_i || data_wr_i)   armed_q <= 1'b0;

      if (stat_rd_i)      fault_arm_q <= fl_q.fault;
      else if (ctrl_wr_i) fault_arm_q <= 1'b0;

      if (done_i)       fl_q.done <= 1'b1;
      else if (seq_clr) fl_q.done <= 1'b0;

      if (wr_accept_o && busy_i) fl_q.coll <= 1'b1;
      else if (seq_clr)          fl_q.coll <= 1'b0;

      if (done_i && fl_q.done) fl_q.ovrn <= 1'b1;
      else if (stat_rd_i)      fl_q.ovrn <= 1'b0;

      if (fault_evt_i)                   fl_q.fault <= 1'b1;
      else if (fault_arm_q && ctrl_wr_i) fl_q.fault <= 1'b0;
    end
  end

  assign flags_o = fl_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SCK_HALF    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          miso_i,
  input  logic          ss_ni
);
  logic en_q, mstr_q, ie_q;
  logic sod_q, ssm_q, ssi_q;
  logic [DW-1:0] rx_buf;

  logic ctrl_wr, stat_wr, stat_rd, data_wr, data_rd;
  assign ctrl_wr = wr_en_i && addr_i == REG_CTRL;
  assign stat_wr = wr_en_i && addr_i == REG_STAT;
  assign stat_rd = rd_en_i && addr_i == REG_STAT;
  assign data_wr = wr_en_i && addr_i == REG_DATA;
  assign data_rd = rd_en_i && addr_i == REG_DATA;

  logic wdata_unused;
  assign wdata_unused = ^wdata_i[DW-1:3];

  logic [2:0] pin_sync;
  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, mosi_i}),
    .q_o   (pin_sync)
  );

  logic ss_int, fault_evt;
  assign ss_int    = ssm_q ? ssi_q : pin_sync[2];
  assign fault_evt = en_q && mstr_q && !ss_int;

  logic eng_busy, eng_done, eng_sck, eng_sdo;
  logic [DW-1:0] eng_rx;
  flags_t flags;
  logic armed, wr_accept, rx_load;

  spi_flag_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_rd_i  (stat_rd),
    .data_rd_i  (data_rd),
    .data_wr_i  (data_wr),
    .ctrl_wr_i  (ctrl_wr),
    .done_i     (eng_done),
    .busy_i     (eng_busy),
    .fault_evt_i(fault_evt),
    .flags_o    (flags),
    .armed_o    (armed),
    .wr_accept_o(wr_accept),
    .rx_load_o  (rx_load)
  );

  spi_shift_engine #(.DW(DW), .SCK_HALF(SCK_HALF)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .mstr_i  (mstr_q),
    .load_i  (wr_accept && !eng_busy && en_q),
    .tx_i    (wdata_i),
    .miso_i  (miso_i),
    .s_sck_i (pin_sync[1]),
    .s_mosi_i(pin_sync[0]),
    .s_sel_i (!ss_int),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .sck_o   (eng_sck),
    .sdo_o   (eng_sdo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mstr_q <= 1'b0;
      ie_q   <= 1'b0;
      sod_q  <= 1'b0;
      ssm_q  <= 1'b0;
      ssi_q  <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) ie_q <= wdata_i[CTRL_IE];
      // fault release beats a concurrent control write
      if (fault_evt) begin
        en_q   <= 1'b0;
        mstr_q <= 1'b0;
      end else if (ctrl_wr) begin
        en_q   <= wdata_i[CTRL_EN];
        mstr_q <= wdata_i[CTRL_MSTR];
      end
      if (stat_wr) begin
        sod_q <= wdata_i[ST_SOD];
        ssm_q <= wdata_i[ST_SSM];
        ssi_q <= wdata_i[ST_SSI];
      end
      if (rx_load) rx_buf <= eng_rx;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = DW'({ie_q, mstr_q, en_q});
      REG_STAT: rdata_o = DW'({flags, 1'b0, sod_q, ssm_q, ssi_q});
      REG_DATA: rdata_o = rx_buf;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o     = ie_q && (flags.done || flags.ovrn || flags.fault);
  assign sck_o     = eng_sck;
  assign sck_oe_o  = en_q && mstr_q;
  assign mosi_o    = eng_sdo;
  assign mosi_oe_o = en_q && mstr_q && !sod_q;
  assign miso_o    = eng_sdo;
  assign miso_oe_o = en_q && !mstr_q && !sod_q && !ss_int;
endmodule

// File: rtl/spi_flag_unit_chk.sv
module spi_flag_unit_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done,
  input logic          spif,
  input logic          armed,
  input logic          busy,
  input logic          data_wr,
  input logic          wcol,
  input logic          fault,
  input logic          en,
  input logic          mstr,
  input logic [DW-1:0] rx_buf,
  input logic          sck
);
  AST_DONE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> spif); // R2

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && mstr && !busy) |-> !sck); // R2

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spif) |-> $past(armed)); // R4

  AST_LOCKED_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && mstr && data_wr && spif && !armed && !busy) |=> !busy); // R5

  AST_COLL_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol) |-> $past(busy)); // R6

  AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && spif) |=> $stable(rx_buf)); // R7

  AST_FAULT_DROPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault) |-> !en); // R8
endmodule

bind spi_flag_unit spi_flag_unit_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .done   (eng_done),
  .spif   (flags.done),
  .armed  (armed),
  .busy   (eng_busy),
  .data_wr(data_wr),
  .wcol   (flags.coll),
  .fault  (flags.fault),
  .en     (en_q),
  .mstr   (mstr_q),
  .rx_buf (rx_buf),
  .sck    (eng_sck)
);

// File: tb/tb_spi_flag_unit.sv
`timescale 1ns/1ps
module tb_spi_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;
  logic miso_i;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  spi_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_o(sck_o), .sck_oe_o(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe), .miso_i(miso_i), .ss_ni(ss_ni)
  );

  // external slave model for master-mode runs
  logic [7:0] sl_tx = '0;
  logic [7:0] sl_rx = '0;
  logic mdl_clr = 1'b0;
  int fall_cnt = 0;
  int sck_rises = 0;
  always @(negedge sck_o or posedge mdl_clr)
    if (mdl_clr) fall_cnt <= 0; else fall_cnt <= fall_cnt + 1;
  always @(posedge sck_o) begin
    sl_rx <= {sl_rx[6:0], mosi_o};
    sck_rises <= sck_rises + 1;
  end
  assign miso_i = (fall_cnt < 8) ? sl_tx[7 - fall_cnt] : 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_model(input logic [7:0] tx);
    sl_tx = tx;
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    bus_rd(2'd1, v); check("R1 status", v, 8'h00);
    bus_rd(2'd2, v); check("R1 data", v, 8'h00);
    check("R1 irq/oe", {4'b0, irq, sck_oe, mosi_oe, miso_oe}, 8'h00);
  endtask

  task automatic t_stat_bits;
    logic [7:0] v;
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, v); check("R11 ro flags, bit3 zero", v, 8'h07);
    bus_wr(2'd1, 8'h00);
  endtask

  task automatic t_master_basic;
    logic [7:0] v;
    bus_wr(2'd0, 8'h07);
    start_model(8'hA5);
    bus_wr(2'd2, 8'h3C);
    wait_clk(50);
    check("R2 mosi MSB first", sl_rx, 8'h3C);
    check("R3 irq on complete", {7'b0, irq}, 8'h01);
    bus_rd(2'd2, v); check("R2 rx byte", v, 8'hA5);
    bus_rd(2'd1, v); check("R4 data read w/o status keeps flag", v, 8'h80);
    bus_rd(2'd1, v); check("R4 re-arm keeps flag", v, 8'h80);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R4 status-then-data clears", v, 8'h00);
    check("R3 irq cleared", {7'b0, irq}, 8'h00);
    check("R2 sck idle low", {7'b0, sck_o}, 8'h00);
  endtask

  task automatic t_lockout;
    logic [7:0] v;
    int rises;
    bus_wr(2'd0, 8'h03);
    start_model(8'h00);
    bus_wr(2'd2, 8'h11);
    wait_clk(50);
    check("R3 no irq when disabled", {7'b0, irq}, 8'h00);
    rises = sck_rises;
    bus_wr(2'd2, 8'h99);
    wait_clk(50);
    check("R5 locked write starts nothing", 8'(sck_rises - rises), 8'h00);
    bus_rd(2'd1, v); check("R5 locked write sets no flag", v, 8'h80);
    start_model(8'h00);
    bus_wr(2'd2, 8'h22);
    wait_clk(50);
    check("R5 write accepted after status read", sl_rx, 8'h22);
    bus_rd(2'd1, v);
    bus_rd(2'd2, v);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    start_model(8'h00);
    bus_wr(2'd2, 8'h81);
    bus_wr(2'd2, 8'h7E);
    wait_clk(50);
    check("R6 byte in flight undisturbed", sl_rx, 8'h81);
    bus_rd(2'd1, v); check("R6 collision flag", v, 8'hC0);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R6 collision cleared", v, 8'h00);
  endtask

  task automatic t_sod_master;
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd1, 8'h04);
    check("R9 mosi released", {6'b0, sck_oe, mosi_oe}, 8'h02);
    bus_wr(2'd1, 8'h00);
    check("R9 mosi driven", {6'b0, sck_oe, mosi_oe}, 8'h03);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic ext_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = b[i];
      wait_clk(6);
      got[i] = miso_o;
      sck_i = 1'b1;
      wait_clk(6);
      sck_i = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic t_slave;
    logic [7:0] v, got;
    bus_wr(2'd0, 8'h05);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'hC3);
    ss_ni = 1'b0;
    wait_clk(6);
    check("R12 miso enabled when selected", {7'b0, miso_oe}, 8'h01);
    ext_byte(8'h6D, got);
    check("R12 miso byte", got, 8'hC3);
    bus_rd(2'd1, v); check("R12 slave complete", v, 8'h80);
    ext_byte(8'h12, got);
    bus_rd(2'd1, v); check("R7 overrun flag", v, 8'hA0);
    check("R3 irq on overrun", {7'b0, irq}, 8'h01);
    bus_rd(2'd1, v); check("R7 status read clears overrun", v, 8'h80);
    bus_rd(2'd2, v); check("R7 first byte kept", v, 8'h6D);
    bus_rd(2'd1, v); check("R7 all clear", v, 8'h00);
    bus_wr(2'd1, 8'h04);
    check("R9 miso released", {7'b0, miso_oe}, 8'h00);
    bus_wr(2'd1, 8'h00);
    ss_ni = 1'b1;
    wait_clk(6);
    check("R12 miso off when deselected", {7'b0, miso_oe}, 8'h00);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_fault;
    logic [7:0] v;
    bus_wr(2'd0, 8'h07);
    bus_wr(2'd1, 8'h03);
    ss_ni = 1'b0;
    wait_clk(6);
    bus_rd(2'd1, v); check("R10 pin ignored under sw select", v, 8'h03);
    bus_rd(2'd0, v); check("R10 ctrl intact", v, 8'h07);
    bus_wr(2'd1, 8'h02);
    wait_clk(3);
    check("R8 outputs released", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);
    check("R3 irq on fault", {7'b0, irq}, 8'h01);
    bus_rd(2'd0, v); check("R8 en/master cleared", v, 8'h04);
    bus_wr(2'd0, 8'h04);
    bus_rd(2'd1, v); check("R8 ctrl write w/o status read keeps fault", v, 8'h12);
    bus_wr(2'd0, 8'h04);
    bus_rd(2'd1, v); check("R8 fault cleared", v, 8'h02);
    check("R3 irq cleared after fault", {7'b0, irq}, 8'h00);
    bus_wr(2'd1, 8'h00);
    ss_ni = 1'b1;
    bus_wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_stat_bits();
    t_master_basic();
    t_lockout();
    t_collision();
    t_sod_master();
    t_slave();
    t_fault();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule